// File: doc/BRIEF.md
# Card Clock Update Controller

This block produces the clock that an SD/MMC-style host drives to its card. Software never changes the running clock directly. It first writes staging registers: an enable flag, a selector that picks one of several staged divider values, and the staged dividers themselves. It then issues an update-clocks command through a command register. The block accepts that command, optionally holds it until the data path reports that the current transfer has finished, and then copies the staged values into the active clock generator in one step. Finally it clears the command bits, and that cleared state is the only completion signal software gets.

The generator divides the source clock (the block's own `clk_i`) by twice the loaded divider. A divider of zero forwards the source clock unchanged. Enabling and disabling are glitch-free. A divided high phase always runs to its full length before the clock stops. The forwarded path is switched on and off only while the source clock is low. A command that arrives while another command holds the command path is refused, and a sticky lock-error flag is raised.

Top module: `cclk_update_ctrl`

## Requirements
- R1: Writes to the enable (address 0), selector (address 1) and divider (addresses 4 + i) staging registers leave `cclk_o` unchanged until an update-clocks command is applied.
- R2: The update-clocks command is a write to address 2 with bit 0 (start) and bit 1 (update-only) both set. A command write that lacks either bit leaves address 2 reading 0 and applies nothing.
- R3: If bit 2 (wait-for-data) is set with the command, the staged values are not applied while `data_busy_i` is high. Without that bit they are applied regardless of `data_busy_i`.
- R4: While an accepted command is pending, address 2 reads back its start, update-only and wait bits. When it is applied, address 2 reads 0.
- R5: Address 3 bit 0 (command done) is set only by a `cmd_done_i` pulse, never by completing an update-clocks command. `irq_o` is the OR of the address 3 bits.
- R6: An update-clocks command written while `cmd_busy_i` is high, or while another update is still pending, is refused. Address 3 bit 1 (lock error) is set, the refused command leaves the start bit clear, and a pending command is kept. The bits of address 3 are cleared by writing 1 to them.
- R7: With the applied enable at 0, `cclk_o` stays low. Applying enable 1 resumes generation at the divider loaded by the same update.
- R8: For an applied nonzero divider N, `cclk_o` is high for N and low for N cycles of `clk_i`. For N = 0, `cclk_o` follows `clk_i`.
- R9: The applied divider is the staged divider whose index is held in the selector register (address 1).
- R10: Every divided high phase of `cclk_o` lasts a full N cycles, including the last one before the clock is disabled. The first low phase after enabling lasts at least N cycles.
- R11: After reset, all registers read 0, `irq_o` is 0 and `cclk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock and register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for writes and reads |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data at `addr_i` |
| data_busy_i | input | 1 | Data transfer in progress |
| cmd_busy_i | input | 1 | Card command path already holds a command |
| cmd_done_i | input | 1 | Pulse: a card command completed |
| cclk_o | output | 1 | Card clock |
| irq_o | output | 1 | Interrupt, OR of the status bits |

## Verification
The assertions assume that `data_busy_i`, `cmd_busy_i` and `cmd_done_i` are synchronous to `clk_i` and change only away from its rising edge. They also assume that every staged selector value names an existing divider. The bench drives every input on the falling edge and writes only selector values below the divider count. The runt-pulse checks assume that software changes a nonzero divider only through a disable-then-enable sequence or while the clock is in its high phase. The bench stages a new divider only while generation is enabled, or switches between disabled and enabled states, and it never reloads a divider in the middle of a low phase.

// File: rtl/cclk_pkg.sv
package cclk_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } upd_state_e;

    localparam int unsigned A_ENA  = 0;
    localparam int unsigned A_SRC  = 1;
    localparam int unsigned A_CMD  = 2;
    localparam int unsigned A_INT  = 3;
    localparam int unsigned A_DIV0 = 4;

    localparam int unsigned CMD_START = 0;
    localparam int unsigned CMD_UPD   = 1;
    localparam int unsigned CMD_WAIT  = 2;

    localparam int unsigned INT_DONE = 0;
    localparam int unsigned INT_LOCK = 1;

endpackage

// File: rtl/cclk_regs.sv
module cclk_regs
    import cclk_pkg::*;
#(
    parameter int unsigned NUM_DIV = 4,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              data_busy_i,
    input  logic              cmd_busy_i,
    input  logic              cmd_done_i,
    output logic              act_ena_o,
    output logic [DIV_W-1:0]  act_div_o,
    output logic              irq_o
);

    localparam int unsigned SRC_W = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;

    typedef struct packed {
        logic                              ena_s;
        logic [SRC_W-1:0]                  src_s;
        logic [NUM_DIV-1:0][DIV_W-1:0]     div_s;
        logic                              start;
        logic                              upd;
        logic                              wait_d;
        upd_state_e                        st;
        logic [1:0]                        intst;
        logic                              act_ena;
        logic [DIV_W-1:0]                  act_div;
    } regs_t;

    regs_t q, d;
    logic  lock_set;
    logic  apply;
    logic  upd_req;
    logic  [DIV_W-1:0] sel_div;

    assign upd_req = wr_en_i && (addr_i == ADDR_W'(A_CMD))
                     && wdata_i[CMD_START] && wdata_i[CMD_UPD];

    always_comb begin
        sel_div = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (q.src_s == SRC_W'(i)) sel_div = q.div_s[i];
        end
    end

    always_comb begin
        d        = q;
        lock_set = 1'b0;
        apply    = 1'b0;

        // apply staged values once the optional data wait is over
        if (q.st == ST_PEND && !(q.wait_d && data_busy_i)) begin
            apply     = 1'b1;
            d.act_ena = q.ena_s;
            d.act_div = sel_div;
            d.start   = 1'b0;
            d.upd     = 1'b0;
            d.wait_d  = 1'b0;
            d.st      = ST_IDLE;
        end

        if (wr_en_i) begin
            if (addr_i == ADDR_W'(A_ENA)) begin
                d.ena_s = wdata_i[0];
            end else if (addr_i == ADDR_W'(A_SRC)) begin
                d.src_s = wdata_i[SRC_W-1:0];
            end else if (addr_i == ADDR_W'(A_INT)) begin
                d.intst = q.intst & ~wdata_i[1:0];
            end else if (addr_i == ADDR_W'(A_CMD)) begin
                if (upd_req) begin
                    if (cmd_busy_i || q.st == ST_PEND) begin
                        lock_set = 1'b1;
                    end else begin
                        d.start  = 1'b1;
                        d.upd    = 1'b1;
                        d.wait_d = wdata_i[CMD_WAIT];
                        d.st     = ST_PEND;
                    end
                end
            end else begin
                for (int i = 0; i < NUM_DIV; i++) begin
                    if (addr_i == ADDR_W'(A_DIV0 + i)) d.div_s[i] = wdata_i[DIV_W-1:0];
                end
            end
        end

        if (cmd_done_i) d.intst[INT_DONE] = 1'b1;
        if (lock_set)   d.intst[INT_LOCK] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_ENA)) begin
            rdata_o[0] = q.ena_s;
        end else if (addr_i == ADDR_W'(A_SRC)) begin
            rdata_o[SRC_W-1:0] = q.src_s;
        end else if (addr_i == ADDR_W'(A_CMD)) begin
            rdata_o[2:0] = {q.wait_d, q.upd, q.start};
        end else if (addr_i == ADDR_W'(A_INT)) begin
            rdata_o[1:0] = q.intst;
        end else begin
            for (int i = 0; i < NUM_DIV; i++) begin
                if (addr_i == ADDR_W'(A_DIV0 + i)) rdata_o[DIV_W-1:0] = q.div_s[i];
            end
        end
    end

    assign act_ena_o = q.act_ena;
    assign act_div_o = q.act_div;
    assign irq_o     = |q.intst;

    // R1
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |=> ($stable(act_div_o) && $stable(act_ena_o)));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PEND && q.wait_d && data_busy_i) |=> (q.st == ST_PEND && q.start));

    // R4
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PEND && !(q.wait_d && data_busy_i)) |=> (!q.start && !q.upd && q.st == ST_IDLE));

    // R5
    no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done_i |=> !$rose(q.intst[INT_DONE]));

    // R6
    lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && cmd_busy_i) |=> q.intst[INT_LOCK]);

endmodule

// File: rtl/cclk_divgen.sv
module cclk_divgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             div_clk_o,
    output logic             byp_req_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] half;
        logic             clk;
    } gen_t;

    gen_t q, d;
    logic run;

    assign run = en_i && (div_i != '0);

    always_comb begin
        d = q;
        if (q.clk) begin
            // a high phase always completes at the length it started with
            if (q.cnt == q.half - 1'b1) begin
                d.clk = 1'b0;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (run) begin
            if (q.cnt >= div_i - 1'b1) begin
                d.clk  = 1'b1;
                d.cnt  = '0;
                d.half = div_i;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign div_clk_o = q.clk;
    assign byp_req_o = en_i && (div_i == '0);

    // R10
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.clk) |-> ($past(q.cnt) == $past(q.half) - 1'b1));

    // R7
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !q.clk) |=> !q.clk);

endmodule

// File: rtl/cclk_gate.sv
module cclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic gclk_o
);

    logic gate_d, gate_q;

    always_comb gate_d = en_i;

    // enable changes only while the source clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign gclk_o = clk & gate_q;

endmodule

// File: rtl/cclk_update_ctrl.sv
module cclk_update_ctrl #(
    parameter int unsigned NUM_DIV = 4,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              data_busy_i,
    input  logic              cmd_busy_i,
    input  logic              cmd_done_i,
    output logic              cclk_o,
    output logic              irq_o
);

    logic             act_ena;
    logic [DIV_W-1:0] act_div;
    logic             div_clk;
    logic             byp_req;
    logic             byp_clk;

    cclk_regs #(
        .NUM_DIV(NUM_DIV), .DIV_W(DIV_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk_i), .rst_n(rst_ni),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .data_busy_i(data_busy_i), .cmd_busy_i(cmd_busy_i), .cmd_done_i(cmd_done_i),
        .act_ena_o(act_ena), .act_div_o(act_div), .irq_o(irq_o)
    );

    cclk_divgen #(.DIV_W(DIV_W)) u_divgen (
        .clk(clk_i), .rst_n(rst_ni),
        .en_i(act_ena), .div_i(act_div),
        .div_clk_o(div_clk), .byp_req_o(byp_req)
    );

    cclk_gate u_gate (
        .clk(clk_i), .rst_n(rst_ni),
        .en_i(byp_req), .gclk_o(byp_clk)
    );

    assign cclk_o = div_clk | byp_clk;

endmodule

// File: tb/cclk_update_ctrl_test.sv
module cclk_update_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        data_busy = 1'b0;
    logic        cmd_busy = 1'b0;
    logic        cmd_done = 1'b0;
    logic        cclk;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cclk_update_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .data_busy_i(data_busy),
        .cmd_busy_i(cmd_busy), .cmd_done_i(cmd_done), .cclk_o(cclk), .irq_o(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wdata = 32'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        addr = 4'(a);
        #1 v = int'(rdata);
    endtask

    task automatic wait_clear(input string req);
        int v = 7;
        for (int i = 0; i < 100 && v != 0; i++) rd(2, v);
        check(req, v, 0);
    endtask

    task automatic sample(output logic s);
        @(posedge clk); #2 s = cclk;
    endtask

    task automatic meas(output int hi, output int lo);
        logic p, c;
        int t;
        hi = 0; lo = 0;
        sample(p);
        for (t = 0; t < 3000; t++) begin
            sample(c);
            if (!p && c) break;
            p = c;
        end
        if (t == 3000) return;
        hi = 1;
        for (int i = 0; i < 3000; i++) begin
            sample(c);
            if (!c) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 3000; i++) begin
            sample(c);
            if (c) break;
            lo++;
        end
    endtask

    task automatic quiet(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2 if (cclk) highs++;
            @(negedge clk); #2 if (cclk) highs++;
        end
    endtask

    task automatic chk_period(input string req, input int n);
        int hi, lo;
        meas(hi, lo);
        check({req, " high"}, hi, n);
        check({req, " low"}, lo, n);
    endtask

    task automatic t_reset;
        int v, h;
        rd(2, v); check("R11 cmd", v, 0);
        rd(3, v); check("R11 intstat", v, 0);
        rd(4, v); check("R11 div0", v, 0);
        check("R11 irq", int'(irq), 0);
        quiet(20, h); check("R11 cclk", h, 0);
    endtask

    task automatic t_staging;
        int v, h;
        wr(0, 1); wr(1, 0); wr(4, 2);
        quiet(40, h); check("R1 no effect", h, 0);
        rd(2, v); check("R1 cmd idle", v, 0);
        wr(2, 3);
        wait_clear("R4 cleared");
        chk_period("R8 div2", 2);
        rd(3, v); check("R5 no done", v, 0);
        check("R5 irq", int'(irq), 0);
    endtask

    task automatic t_src;
        wr(5, 5); wr(1, 1);
        chk_period("R1 staged src", 2);
        wr(2, 3); wait_clear("R4 cleared src");
        chk_period("R9 src1", 5);
        wr(1, 0);
    endtask

    task automatic t_wait;
        int v;
        data_busy = 1'b1;
        wr(4, 3);
        wr(2, 7);
        repeat (20) @(negedge clk);
        rd(2, v); check("R4 pending bits", v, 7);
        chk_period("R3 held", 5);
        @(negedge clk) data_busy = 1'b0;
        wait_clear("R3 released");
        chk_period("R3 applied", 3);
    endtask

    task automatic t_nowait;
        @(negedge clk) data_busy = 1'b1;
        wr(4, 4); wr(2, 3);
        wait_clear("R3 no wait");
        chk_period("R3 no wait div", 4);
        @(negedge clk) data_busy = 1'b0;
    endtask

    task automatic t_lock;
        int v;
        @(negedge clk) cmd_busy = 1'b1;
        wr(4, 6); wr(2, 3);
        rd(2, v); check("R6 start clear", v, 0);
        rd(3, v); check("R6 lock bit", v, 2);
        check("R6 irq", int'(irq), 1);
        chk_period("R6 unchanged", 4);
        wr(3, 2);
        rd(3, v); check("R6 w1c", v, 0);
        @(negedge clk) cmd_busy = 1'b0;
        @(negedge clk) data_busy = 1'b1;
        wr(2, 7);
        wr(2, 3);
        rd(3, v); check("R6 second lock", v, 2);
        rd(2, v); check("R6 pending kept", v, 7);
        @(negedge clk) data_busy = 1'b0;
        wait_clear("R6 pending done");
        chk_period("R6 applied", 6);
        wr(3, 3);
    endtask

    task automatic t_done;
        int v;
        @(negedge clk) cmd_done = 1'b1;
        @(negedge clk) cmd_done = 1'b0;
        rd(3, v); check("R5 done bit", v, 1);
        check("R5 irq done", int'(irq), 1);
        wr(3, 1);
        rd(3, v); check("R5 done cleared", v, 0);
    endtask

    task automatic t_ignored;
        int v;
        wr(4, 2);
        wr(2, 1);
        rd(2, v); check("R2 start only", v, 0);
        wr(2, 2);
        rd(2, v); check("R2 update only", v, 0);
        chk_period("R2 nothing applied", 6);
    endtask

    task automatic t_enable;
        int h;
        wr(0, 0); wr(2, 3); wait_clear("R7 off cmd");
        repeat (20) @(negedge clk);
        quiet(60, h); check("R7 stopped", h, 0);
        wr(0, 1); wr(2, 3); wait_clear("R7 on cmd");
        chk_period("R10 resume", 2);
    endtask

    task automatic t_bypass;
        int hi = 0, lo = 0, h;
        wr(4, 0); wr(2, 3); wait_clear("R8 byp cmd");
        repeat (4) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #2 if (cclk) hi++;
            @(negedge clk); #2 if (cclk) lo++;
        end
        check("R8 bypass high", hi, 10);
        check("R8 bypass low", lo, 0);
        wr(0, 0); wr(2, 3); wait_clear("R7 byp off");
        quiet(20, h); check("R7 byp stopped", h, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_staging();
        t_src();
        t_wait();
        t_nowait();
        t_lock();
        t_done();
        t_ignored();
        t_enable();
        t_bypass();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule